// File: doc/BRIEF.md
# Clock-Enable Power State Controller

This block follows the clock-enable and power condition of a command-driven synchronous memory. On each rising clock edge it samples clock enable, chip select, the three active-low command strobes (row strobe, column strobe, write enable) and a flag that reports whether every bank is precharged. From these samples it keeps one of five power states. It drives a registered clock-valid qualifier that the rest of the device uses to gate command execution.

Three cases of clock enable sampled low are kept apart. If a bank is open, the following cycle is masked (clock suspend). If all banks are precharged, the device goes to power-down. If the device is idle and a specific strobe pattern is present with chip select low, it goes to deep power-down. Leaving deep power-down returns the device to idle and raises a flag saying that the mode register has lost its contents. A mode-load command clears that flag.

Top module: `cke_power_ctrl`

## Requirements
- R1: After reset, `pwr_state_o` is IDLE (encoding IDLE=0, ACTIVE=1, SUSPEND=2, PDOWN=3, DPDOWN=4), `clk_valid_o` is 1 and `reprog_req_o` is 0.
- R2: While the state is IDLE, ACTIVE, SUSPEND or PDOWN and clock enable is sampled high, the next state is IDLE if `banks_idle_i` is 1 and ACTIVE if it is 0.
- R3: In IDLE or ACTIVE, clock enable sampled low with `banks_idle_i`=0 gives SUSPEND on the next cycle. In SUSPEND, each further low sample keeps the state in SUSPEND for one more cycle. `clk_valid_o` is low exactly in the cycles spent in SUSPEND, PDOWN or DPDOWN.
- R4: In IDLE or ACTIVE, clock enable sampled low with `banks_idle_i`=1 and no accepted deep-power-down pattern gives PDOWN. The state stays in PDOWN while clock enable stays low.
- R5: Deep power-down is entered (state DPDOWN) when all of the following are sampled together: state IDLE, `banks_idle_i`=1, clock enable low, `cs_n_i`=0, `ras_n_i`=1, `cas_n_i`=1 and `we_n_i`=0. The state stays in DPDOWN while clock enable stays low.
- R6: With `cs_n_i`=1 the command strobes are ignored, so the deep-power-down pattern gives PDOWN instead. The same pattern sampled in ACTIVE gives SUSPEND.
- R7: From PDOWN, the first high sample of clock enable restores `clk_valid_o` to 1 on the next cycle.
- R8: From DPDOWN, a high sample of clock enable gives IDLE and sets `reprog_req_o` to 1 on the next cycle, whatever the value of `banks_idle_i`.
- R9: `reprog_req_o` is cleared only by a mode-load command sampled in IDLE: clock enable high, `cs_n_i`=0, `ras_n_i`=0, `cas_n_i`=0 and `we_n_i`=0. Any other command leaves it set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_i | input | 1 | Clock enable, active high |
| cs_n_i | input | 1 | Chip select, active low |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable strobe, active low |
| banks_idle_i | input | 1 | 1 when every bank is precharged |
| clk_valid_o | output | 1 | 1 when the current cycle may execute commands |
| pwr_state_o | output | 3 | Current power state (encoding in R1) |
| reprog_req_o | output | 1 | 1 after deep power-down until a mode load |

## Verification
The assertions check every cycle that a low clock-enable sample taken with an open bank masks the next cycle. They also check that an idle low sample reaches power-down or deep power-down as the strobes select, and that both low-power exits restore the clock qualifier, with the reprogram flag set after a deep exit. Other behaviours show only in the bench's directed scenarios: chip select high hiding the deep pattern, the same pattern taken in ACTIVE becoming a plain mask, a run of masked cycles whose length matches the run of low samples, and the reprogram flag surviving ordinary commands until a mode load arrives.

// File: rtl/cke_power_pkg.sv
package cke_power_pkg;

    localparam int STATE_W = 3;

    typedef enum logic [STATE_W-1:0] {
        PS_IDLE    = 3'd0,
        PS_ACTIVE  = 3'd1,
        PS_SUSPEND = 3'd2,
        PS_PDOWN   = 3'd3,
        PS_DPDOWN  = 3'd4
    } pwr_state_e;

    typedef struct packed {
        logic deep_req;   // deep power-down strobe pattern, chip selected
        logic mode_load;  // mode-load command with clock enable high
    } cmd_flags_t;

    typedef struct packed {
        pwr_state_e state;
        logic       valid;
    } fsm_reg_t;

    typedef struct packed {
        logic reprog;
    } flag_reg_t;

endpackage

// File: rtl/cke_cmd_decode.sv
module cke_cmd_decode
    import cke_power_pkg::*;
(
    input  logic       cke_i,
    input  logic       cs_n_i,
    input  logic       ras_n_i,
    input  logic       cas_n_i,
    input  logic       we_n_i,
    output cmd_flags_t flags_o
);
    logic selected;

    always_comb begin
        selected          = !cs_n_i;
        flags_o.deep_req  = selected && ras_n_i && cas_n_i && !we_n_i;
        flags_o.mode_load = selected && cke_i && !ras_n_i && !cas_n_i && !we_n_i;
    end
endmodule

// File: rtl/cke_state_fsm.sv
module cke_state_fsm
    import cke_power_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cke_i,
    input  logic       banks_idle_i,
    input  cmd_flags_t flags_i,
    output pwr_state_e state_o,
    output logic       valid_o,
    output logic       deep_exit_o
);
    fsm_reg_t r_d, r_q;
    pwr_state_e run_state;

    always_comb begin
        run_state   = banks_idle_i ? PS_IDLE : PS_ACTIVE;
        r_d         = r_q;
        deep_exit_o = 1'b0;
        case (r_q.state)
            PS_IDLE, PS_ACTIVE: begin
                if (cke_i) begin
                    r_d.state = run_state;
                end else if (flags_i.deep_req && banks_idle_i && r_q.state == PS_IDLE) begin
                    r_d.state = PS_DPDOWN;
                end else if (banks_idle_i) begin
                    r_d.state = PS_PDOWN;
                end else begin
                    r_d.state = PS_SUSPEND;
                end
            end
            PS_SUSPEND: r_d.state = cke_i ? run_state : PS_SUSPEND;
            PS_PDOWN:   r_d.state = cke_i ? run_state : PS_PDOWN;
            PS_DPDOWN: begin
                if (cke_i) begin
                    r_d.state   = PS_IDLE;
                    deep_exit_o = 1'b1;
                end
            end
            default: r_d.state = PS_IDLE;
        endcase
        r_d.valid = (r_d.state == PS_IDLE) || (r_d.state == PS_ACTIVE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= PS_IDLE;
            r_q.valid <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.state;
    assign valid_o = r_q.valid;
endmodule

// File: rtl/cke_reprog_flag.sv
module cke_reprog_flag
    import cke_power_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       deep_exit_i,
    input  pwr_state_e state_i,
    input  cmd_flags_t flags_i,
    output logic       reprog_o
);
    flag_reg_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (deep_exit_i) begin
            f_d.reprog = 1'b1;
        end else if (state_i == PS_IDLE && flags_i.mode_load) begin
            f_d.reprog = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.reprog <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign reprog_o = f_q.reprog;
endmodule

// File: rtl/cke_power_ctrl.sv
module cke_power_ctrl
    import cke_power_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cke_i,
    input  logic               cs_n_i,
    input  logic               ras_n_i,
    input  logic               cas_n_i,
    input  logic               we_n_i,
    input  logic               banks_idle_i,
    output logic               clk_valid_o,
    output logic [STATE_W-1:0] pwr_state_o,
    output logic               reprog_req_o
);
    cmd_flags_t flags;
    pwr_state_e state;
    logic       deep_exit;

    cke_cmd_decode u_decode (
        .cke_i   (cke_i),
        .cs_n_i  (cs_n_i),
        .ras_n_i (ras_n_i),
        .cas_n_i (cas_n_i),
        .we_n_i  (we_n_i),
        .flags_o (flags)
    );

    cke_state_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cke_i        (cke_i),
        .banks_idle_i (banks_idle_i),
        .flags_i      (flags),
        .state_o      (state),
        .valid_o      (clk_valid_o),
        .deep_exit_o  (deep_exit)
    );

    cke_reprog_flag u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .deep_exit_i (deep_exit),
        .state_i     (state),
        .flags_i     (flags),
        .reprog_o    (reprog_req_o)
    );

    assign pwr_state_o = state;
endmodule

// File: rtl/cke_power_ctrl_chk.sv
module cke_power_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cke_i,
    input logic       cs_n_i,
    input logic       ras_n_i,
    input logic       cas_n_i,
    input logic       we_n_i,
    input logic       banks_idle_i,
    input logic       clk_valid_o,
    input logic [2:0] pwr_state_o,
    input logic       reprog_req_o
);
    logic pattern;
    logic running;
    assign pattern = !cs_n_i && ras_n_i && cas_n_i && !we_n_i;
    assign running = (pwr_state_o == 3'd0) || (pwr_state_o == 3'd1);

    // R3
    suspend_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cke_i && !banks_idle_i) |=> (!clk_valid_o && pwr_state_o == 3'd2));

    // R4
    pdown_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !cke_i && banks_idle_i && !(pattern && pwr_state_o == 3'd0))
        |=> (pwr_state_o == 3'd3));

    // R5
    dpd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state_o == 3'd0 && !cke_i && banks_idle_i && pattern) |=> (pwr_state_o == 3'd4));

    // R7
    pdown_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state_o == 3'd3 && cke_i) |=> clk_valid_o);

    // R8
    dpd_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_state_o == 3'd4 && cke_i) |=> (pwr_state_o == 3'd0 && reprog_req_o));

    // R9
    reprog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reprog_req_o && !(pwr_state_o == 3'd0 && cke_i && !cs_n_i && !ras_n_i && !cas_n_i && !we_n_i))
        |=> reprog_req_o);
endmodule

bind cke_power_ctrl cke_power_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cke_i        (cke_i),
    .cs_n_i       (cs_n_i),
    .ras_n_i      (ras_n_i),
    .cas_n_i      (cas_n_i),
    .we_n_i       (we_n_i),
    .banks_idle_i (banks_idle_i),
    .clk_valid_o  (clk_valid_o),
    .pwr_state_o  (pwr_state_o),
    .reprog_req_o (reprog_req_o)
);

// File: tb/cke_power_ctrl_tb_top.sv
`timescale 1ns/1ps
module cke_power_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, bidle = 1'b1;
    logic       valid;
    logic [2:0] st;
    logic       reprog;

    int checks = 0;
    int errors = 0;
    int m_state = 0;
    bit m_reprog = 1'b0;

    always #4 clk = ~clk;

    cke_power_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cke_i(cke), .cs_n_i(cs_n), .ras_n_i(ras_n),
        .cas_n_i(cas_n), .we_n_i(we_n), .banks_idle_i(bidle),
        .clk_valid_o(valid), .pwr_state_o(st), .reprog_req_o(reprog)
    );

    task automatic check(input string tag, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Behavioural reference: states 0 idle,1 active,2 suspend,3 pdown,4 deep
    task automatic model_edge();
        bit pat, mrs;
        int run;
        pat = !cs_n && ras_n && cas_n && !we_n;
        mrs = !cs_n && !ras_n && !cas_n && !we_n && cke;
        run = bidle ? 0 : 1;
        if (m_state == 0 && mrs) m_reprog = 1'b0;
        if (m_state == 4) begin
            if (cke) begin m_state = 0; m_reprog = 1'b1; end
        end else if (m_state >= 2) begin
            if (cke) m_state = run;
        end else if (cke) m_state = run;
        else if (m_state == 0 && pat && bidle) m_state = 4;
        else if (bidle) m_state = 3;
        else m_state = 2;
    endtask

    task automatic compare(input string tag);
        check(tag, st, m_state, "state");
        check(tag, valid, (m_state <= 1) ? 1 : 0, "clk_valid");
        check(tag, reprog, m_reprog, "reprog");
    endtask

    // drive at negedge, model at posedge, compare at following negedge
    task automatic step(input string tag, input bit k, input bit c, input bit r,
                        input bit a, input bit w, input bit b);
        cke = k; cs_n = c; ras_n = r; cas_n = a; we_n = w; bidle = b;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic nop(input string tag, input bit k, input bit b);
        step(tag, k, 1'b0, 1'b1, 1'b1, 1'b1, b);
    endtask

    task automatic expect_state(input string tag, input int exp);
        check(tag, st, exp, "directed state");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        check("R1", st, 0, "reset state");
        check("R1", valid, 1, "reset clk_valid");
        check("R1", reprog, 0, "reset reprog");

        // R2 follow bank flag
        nop("R2", 1, 0); expect_state("R2", 1);
        nop("R2", 1, 1); expect_state("R2", 0);
        nop("R2", 1, 0);

        // R3 single and multi-cycle masking
        nop("R3", 0, 0); expect_state("R3", 2);
        nop("R3", 1, 0); expect_state("R3", 1);
        for (int i = 0; i < 3; i++) nop("R3", 0, 0);
        check("R3", valid, 0, "clk_valid after 3 lows");
        nop("R3", 1, 0); check("R3", valid, 1, "clk_valid after release");

        // R4 power-down from idle, R7 exit
        nop("R4", 1, 1);
        nop("R4", 0, 1); expect_state("R4", 3);
        for (int i = 0; i < 4; i++) nop("R4", 0, 1);
        expect_state("R4", 3);
        nop("R7", 1, 1); check("R7", valid, 1, "exit valid");
        // R4 from active with banks now idle
        nop("R4", 1, 0);
        nop("R4", 0, 1); expect_state("R4", 3);
        nop("R7", 1, 0); expect_state("R7", 1);

        // R6 deselected pattern and active pattern
        nop("R6", 1, 1);
        step("R6", 0, 1, 1, 1, 0, 1); expect_state("R6", 3);
        nop("R6", 1, 0);
        step("R6", 0, 0, 1, 1, 0, 0); expect_state("R6", 2);
        nop("R6", 1, 1);

        // R5 deep power-down, R8 exit
        step("R5", 0, 0, 1, 1, 0, 1); expect_state("R5", 4);
        for (int i = 0; i < 5; i++) step("R5", 0, 1, 0, 0, 0, 0);
        expect_state("R5", 4);
        nop("R8", 1, 0); expect_state("R8", 0);
        check("R8", reprog, 1, "reprog after deep exit");

        // R9 other commands keep flag, mode load clears
        step("R9", 1, 0, 0, 1, 0, 1);
        step("R9", 1, 1, 0, 0, 0, 1);
        step("R9", 0, 0, 0, 0, 0, 1);
        nop("R9", 1, 1);
        check("R9", reprog, 1, "flag kept");
        step("R9", 1, 0, 0, 0, 0, 1);
        check("R9", reprog, 0, "flag cleared");
        // R9 mode load in ACTIVE does not clear
        step("R5", 0, 0, 1, 1, 0, 1);
        nop("R8", 1, 0);
        nop("R9", 1, 0);
        step("R9", 1, 0, 0, 0, 0, 0);
        check("R9", reprog, 1, "mode load outside idle");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule